// File: doc/BRIEF.md
# Receive Descriptor Ring Free-Count Tracker

This block keeps the number of receive descriptors in a circular ring that are still available for incoming frames. Hardware owns a current index that steps forward each time a descriptor is taken. Software owns a freed index, which it moves to mark descriptors it has emptied, and it also sets the ring length and a low-water threshold. The block combines these values into a free count. When that count falls to the threshold or below, it requests back pressure, unless the link runs half duplex.

The two indices are equal both when the ring is completely free and when it is completely used. The block separates these cases by remembering which event last made them equal. A software freed-index write, a length write or a restart makes the ring entirely free. A hardware step onto the freed index leaves exactly one descriptor. A write-back of that last descriptor leaves none. Further hardware steps in the last two states are refused and latch a busy flag.

Top module: `rx_ring_free_tracker`

## Requirements
- R1: After reset both indices are 0, the length is 256, the threshold is 0, the free count is 256, and `bp_req` and `busy` are 0.
- R2: When the freed index is larger than the current index, the free count equals freed minus current.
- R3: When the freed index is smaller than the current index, the free count equals length minus (current minus freed).
- R4: A freed-index write (`wr_sel`=1) that makes the freed index equal to the current index gives a free count equal to the length.
- R5: A restart write (`wr_sel`=2) or an accepted length write (`wr_sel`=0) sets both indices to 0, makes the free count equal to the length, and clears `busy`.
- R6: A hardware step (`hw_adv`) that lands the current index on the freed index gives a free count of 1.
- R7: A write-back (`hw_wb`) in the one-left state gives a free count of 0. In any other state `hw_wb` leaves the count unchanged.
- R8: `hw_adv` in the one-left or full state does not move the current index and sets `busy`. `busy` stays set until R5 clears it.
- R9: The current index steps to 0 after index length−1.
- R10: `bp_req` is 1 exactly when the free count is at or below the threshold (`wr_sel`=3) and `half_duplex` is 0.
- R11: Length writes of 0 or above 256 are ignored. Freed-index writes of a value not below the length are ignored.
- R12: In a cycle with `wr_en` high, `hw_adv` and `hw_wb` are dropped and do not set `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 length, 1 freed index, 2 restart, 3 threshold |
| wr_data | input | 9 | Write value |
| half_duplex | input | 1 | Link in half duplex; suppresses back pressure |
| hw_adv | input | 1 | Hardware takes the descriptor at the current index and steps on |
| hw_wb | input | 1 | Hardware has written back the descriptor at the current index |
| free_cnt | output | 9 | Free descriptors |
| bp_req | output | 1 | Back-pressure request |
| busy | output | 1 | Sticky: a step was refused because the ring had no room |

## Verification
Every event is captured on one rising edge. `free_cnt`, `busy` and `bp_req` show the result after that edge with no further delay, because they are built combinationally from the registered state. `bp_req` also follows `half_duplex` and the threshold in the same cycle. The bench drives each event on a falling edge, releases it on the next falling edge, and samples at that moment, one rising edge after the stimulus. Each sample therefore sees exactly one new event, and the refused-step and same-cycle write cases are checked after the edge that could have changed them.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        SEL_LEN     = 2'd0,
        SEL_FREED   = 2'd1,
        SEL_RESTART = 2'd2,
        SEL_THRESH  = 2'd3
    } sel_e;

    // Event that most recently moved an index; decides the equal-index case.
    typedef enum logic [1:0] {
        MATCH_ALL  = 2'd0,
        MATCH_ONE  = 2'd1,
        MATCH_FULL = 2'd2
    } match_e;
endpackage

// File: rtl/rxr_idx_step.sv
module rxr_idx_step #(
    parameter int IDX_W = 8,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] len,
    output logic [IDX_W-1:0] nxt
);
    logic [CNT_W-1:0] plus_one;

    always_comb begin
        plus_one = {1'b0, idx} + CNT_W'(1);
        nxt      = (plus_one >= len) ? '0 : plus_one[IDX_W-1:0];
    end
endmodule

// File: rtl/rxr_free_calc.sv
module rxr_free_calc
    import rxr_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] fr,
    input  logic [CNT_W-1:0] len,
    input  match_e           cause,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cur_w;
    logic [CNT_W-1:0] fr_w;

    always_comb begin
        cur_w = {1'b0, cur};
        fr_w  = {1'b0, fr};
        if (fr_w > cur_w) begin
            cnt = fr_w - cur_w;
        end else if (fr_w < cur_w) begin
            cnt = len - (cur_w - fr_w);
        end else begin
            unique case (cause)
                MATCH_ONE:  cnt = CNT_W'(1);
                MATCH_FULL: cnt = '0;
                default:    cnt = len;
            endcase
        end
    end
endmodule

// File: rtl/rxr_bp_cmp.sv
module rxr_bp_cmp #(
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thresh,
    input  logic             half_duplex,
    output logic             bp_req
);
    always_comb begin
        bp_req = !half_duplex && (cnt <= thresh);
    end
endmodule

// File: rtl/rx_ring_free_tracker.sv
module rx_ring_free_tracker
    import rxr_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int CNT_W = IDX_W + 1,
    localparam int MAX_LEN = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             half_duplex,
    input  logic             hw_adv,
    input  logic             hw_wb,
    output logic [CNT_W-1:0] free_cnt,
    output logic             bp_req,
    output logic             busy
);
    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] fr;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] thr;
        match_e           cause;
        logic             busy;
    } trk_t;

    trk_t             s_d, s_q;
    sel_e             sel;
    logic [IDX_W-1:0] cur_nxt_d;
    logic             equal_q;
    logic             blocked_q;
    logic             len_ok;
    logic             fr_ok;

    assign sel       = sel_e'(wr_sel);
    assign equal_q   = (s_q.cur == s_q.fr);
    assign blocked_q = equal_q && (s_q.cause != MATCH_ALL);
    assign len_ok    = (wr_data != '0) && (wr_data <= CNT_W'(MAX_LEN));
    assign fr_ok     = (wr_data < s_q.len);

    rxr_idx_step #(.IDX_W(IDX_W)) i_step (
        .idx (s_q.cur),
        .len (s_q.len),
        .nxt (cur_nxt_d)
    );

    rxr_free_calc #(.IDX_W(IDX_W)) i_calc (
        .cur   (s_q.cur),
        .fr    (s_q.fr),
        .len   (s_q.len),
        .cause (s_q.cause),
        .cnt   (free_cnt)
    );

    rxr_bp_cmp #(.CNT_W(CNT_W)) i_cmp (
        .cnt         (free_cnt),
        .thresh      (s_q.thr),
        .half_duplex (half_duplex),
        .bp_req      (bp_req)
    );

    assign busy = s_q.busy;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            // Register writes take the cycle; hardware strobes are dropped.
            unique case (sel)
                SEL_LEN: begin
                    if (len_ok) begin
                        s_d.len   = wr_data;
                        s_d.cur   = '0;
                        s_d.fr    = '0;
                        s_d.cause = MATCH_ALL;
                        s_d.busy  = 1'b0;
                    end
                end
                SEL_FREED: begin
                    if (fr_ok) begin
                        s_d.fr    = wr_data[IDX_W-1:0];
                        s_d.cause = MATCH_ALL;
                    end
                end
                SEL_RESTART: begin
                    s_d.cur   = '0;
                    s_d.fr    = '0;
                    s_d.cause = MATCH_ALL;
                    s_d.busy  = 1'b0;
                end
                default: begin
                    s_d.thr = wr_data;
                end
            endcase
        end else begin
            if (hw_adv) begin
                if (blocked_q) begin
                    s_d.busy = 1'b1;
                end else begin
                    s_d.cur   = cur_nxt_d;
                    s_d.cause = MATCH_ONE;
                end
            end
            if (hw_wb && equal_q && (s_q.cause == MATCH_ONE)) begin
                s_d.cause = MATCH_FULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cur   <= '0;
            s_q.fr    <= '0;
            s_q.len   <= CNT_W'(MAX_LEN);
            s_q.thr   <= '0;
            s_q.cause <= MATCH_ALL;
            s_q.busy  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // Count produced by the calculator never exceeds the stored length.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= s_q.len);

    // Both indices stay inside the ring.
    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.cur} < s_q.len) && ({1'b0, s_q.fr} < s_q.len));

    p_restart_all_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RESTART) |=> (free_cnt == s_q.len) && !busy);

    p_refused_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_adv && blocked_q) |=> $stable(s_q.cur) && busy);

    p_last_wb_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_wb && equal_q && s_q.cause == MATCH_ONE) |=> free_cnt == '0);

    p_half_duplex_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        half_duplex |-> !bp_req);

    p_write_drops_hw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_THRESH) |=> $stable(s_q.cur) && (busy == $past(s_q.busy)));
endmodule

// File: tb/test_rx_ring_free_tracker.sv
module test_rx_ring_free_tracker;
    localparam int IDX_W = 8;
    localparam int CNT_W = IDX_W + 1;

    // op: 0 len write, 1 freed write, 2 restart, 3 threshold write, 4 step, 5 write-back
    typedef struct packed {
        logic [2:0] op;
        logic [8:0] data;
        logic [8:0] exp_free;
        logic       exp_bp;
        logic       exp_busy;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 9'd8,   9'd8, 1'b0, 1'b0, 4'd5},  // R5 length 8
        '{3'd3, 9'd2,   9'd8, 1'b0, 1'b0, 4'd10}, // R10 threshold 2
        '{3'd4, 9'd0,   9'd7, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd4, 9'd0,   9'd6, 1'b0, 1'b0, 4'd3},
        '{3'd4, 9'd0,   9'd5, 1'b0, 1'b0, 4'd3},
        '{3'd4, 9'd0,   9'd4, 1'b0, 1'b0, 4'd3},
        '{3'd4, 9'd0,   9'd3, 1'b0, 1'b0, 4'd3},
        '{3'd4, 9'd0,   9'd2, 1'b1, 1'b0, 4'd10}, // R10 at threshold
        '{3'd4, 9'd0,   9'd1, 1'b1, 1'b0, 4'd3},
        '{3'd4, 9'd0,   9'd1, 1'b1, 1'b0, 4'd6},  // R6, R9 wrap onto freed index 0
        '{3'd4, 9'd0,   9'd1, 1'b1, 1'b1, 4'd8},  // R8 refused in one-left
        '{3'd5, 9'd0,   9'd0, 1'b1, 1'b1, 4'd7},  // R7 full
        '{3'd1, 9'd3,   9'd3, 1'b0, 1'b1, 4'd2},  // R2
        '{3'd4, 9'd0,   9'd2, 1'b1, 1'b1, 4'd2},
        '{3'd5, 9'd0,   9'd2, 1'b1, 1'b1, 4'd7},  // R7 no effect
        '{3'd1, 9'd1,   9'd8, 1'b0, 1'b1, 4'd4},  // R4
        '{3'd1, 9'd9,   9'd8, 1'b0, 1'b1, 4'd11}, // R11 freed out of range
        '{3'd0, 9'd0,   9'd8, 1'b0, 1'b1, 4'd11}, // R11 zero length
        '{3'd4, 9'd0,   9'd7, 1'b0, 1'b1, 4'd3},
        '{3'd1, 9'd0,   9'd6, 1'b0, 1'b1, 4'd3},
        '{3'd2, 9'd0,   9'd8, 1'b0, 1'b0, 4'd5},  // R5 restart clears busy
        '{3'd0, 9'd300, 9'd8, 1'b0, 1'b0, 4'd11}  // R11 oversize length
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             half_duplex = 1'b0;
    logic             hw_adv = 1'b0;
    logic             hw_wb = 1'b0;
    logic [CNT_W-1:0] free_cnt;
    logic             bp_req;
    logic             busy;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rx_ring_free_tracker #(.IDX_W(IDX_W)) i_rx_ring_free_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .half_duplex (half_duplex),
        .hw_adv      (hw_adv),
        .hw_wb       (hw_wb),
        .free_cnt    (free_cnt),
        .bp_req      (bp_req),
        .busy        (busy)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(logic [2:0] op, logic [8:0] data);
        @(negedge clk);
        wr_data = data;
        if (op <= 3'd3) begin
            wr_en  = 1'b1;
            wr_sel = op[1:0];
        end else if (op == 3'd4) begin
            hw_adv = 1'b1;
        end else begin
            hw_wb = 1'b1;
        end
        @(negedge clk);
        wr_en  = 1'b0;
        hw_adv = 1'b0;
        hw_wb  = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "free_cnt", int'(free_cnt), 256);
        check("R1", "bp_req", int'(bp_req), 0);
        check("R1", "busy", int'(busy), 0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            step(VEC[i].op, VEC[i].data);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check(tag, "free_cnt", int'(free_cnt), int'(VEC[i].exp_free));
            check(tag, "bp_req", int'(bp_req), int'(VEC[i].exp_bp));
            check(tag, "busy", int'(busy), int'(VEC[i].exp_busy));
        end

        // Two-entry ring driven to full, then duplex mode toggled (R10).
        step(3'd0, 9'd2);
        check("R5", "free_cnt", int'(free_cnt), 2);
        step(3'd4, 9'd0);
        check("R3", "free_cnt", int'(free_cnt), 1);
        step(3'd4, 9'd0);
        check("R6", "free_cnt", int'(free_cnt), 1);
        step(3'd5, 9'd0);
        check("R7", "free_cnt", int'(free_cnt), 0);
        half_duplex = 1'b1;
        @(negedge clk);
        check("R10", "bp_req half duplex", int'(bp_req), 0);
        half_duplex = 1'b0;
        @(negedge clk);
        check("R10", "bp_req full duplex", int'(bp_req), 1);

        // R12: threshold write with a step in the same cycle; step is dropped.
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'd3;
        wr_data = 9'd0;
        hw_adv  = 1'b1;
        hw_wb   = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
        hw_adv = 1'b0;
        hw_wb  = 1'b0;
        check("R12", "busy", int'(busy), 0);
        check("R12", "free_cnt", int'(free_cnt), 0);
        check("R10", "bp_req at zero threshold", int'(bp_req), 1);

        // R8: step while full refused, busy latched, count unchanged.
        step(3'd4, 9'd0);
        check("R8", "busy", int'(busy), 1);
        check("R8", "free_cnt", int'(free_cnt), 0);

        // R9: full 256-entry ring wraps back to index 0.
        step(3'd0, 9'd256);
        check("R5", "busy", int'(busy), 0);
        step(3'd1, 9'd255);
        check("R2", "free_cnt", int'(free_cnt), 255);
        for (int k = 0; k < 255; k++) step(3'd4, 9'd0);
        check("R6", "free_cnt", int'(free_cnt), 1);
        step(3'd1, 9'd10);
        check("R2", "free_cnt", int'(free_cnt), 11);
        step(3'd4, 9'd0);
        check("R9", "free_cnt after wrap", int'(free_cnt), 10);

        finish_run();
    end
endmodule